// File: doc/BRIEF.md
# Synchronizer clock mode controller

This block is the operating-mode state machine that sits beside the loop of a network-synchronization digital PLL. It chooses among four operating states: tracking the reference, holdover entered automatically after the reference is lost, holdover forced by the mode select, and free-run. From that choice it drives control levels toward the loop: a tracking indicator, a holdover indicator, a fast-acquisition enable, and a one-cycle request to suppress the output phase step.

The two-bit mode select comes from another clock domain, so it passes through a two-flop synchronizer before the state register uses it. The reference-valid flag, the fast-acquisition request and the suppression enable are taken as synchronous inputs. Loss and return of the reference switch between tracking and automatic holdover without any software action. A lock timer runs while the block is tracking. It raises a lock flag once a short budget has elapsed (fast acquisition) or a long budget has elapsed (default). Both budgets are parameters, scaled down so that simulation stays short.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, the block is in free-run: `normal_o`, `holdover_o`, `fast_lock_o`, `ts_o` and `lock_o` are all 0.
- R2: After reset the block stays in free-run until the synchronized select first shows 00 or 10. Select 01 or 11 seen before that has no effect, so both indicators stay 0.
- R3: A change on `mode_sel` takes effect on the third rising clock edge after it: two edges pass through the synchronizer and one through the state register. Before that edge the outputs still show the old state.
- R4: Select encodings: 00 requests tracking, 01 requests forced holdover and 10 requests free-run. Under 00 with `ref_valid` low, free-run stays in free-run and forced holdover moves to automatic holdover. Under 00 with `ref_valid` high, the block moves to tracking.
- R5: In tracking with select 00, a low `ref_valid` at a clock edge moves the block to automatic holdover at that edge.
- R6: In automatic holdover with select 00, a high `ref_valid` at a clock edge returns the block to tracking at that edge. Forced holdover under select 01 never returns on its own.
- R7: `normal_o` is 1 exactly in tracking. `holdover_o` is 1 exactly in either holdover state. The two are never 1 together.
- R8: `fast_lock_o` equals `fast_req` while in tracking and is 0 in every other state.
- R9: When the state changes at an edge where `ts_en` is 1, `ts_o` is 1 for the following cycle only. The exception is the automatic return from automatic holdover to tracking: there, `ts_o` stays 0.
- R10: `lock_o` rises FAST_CNT clock edges after entry to tracking when `fast_req` is 1, and SLOW_CNT edges after entry when it is 0. It is 0 outside tracking, and the count restarts from zero on every entry.
- R11: Select 11 is reserved. While the synchronized select is 11, the state does not change, even when `ref_valid` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Requested mode, asynchronous (00 track, 01 hold, 10 free-run, 11 reserved) |
| ref_valid | input | 1 | Reference is present and usable |
| fast_req | input | 1 | Request for fast acquisition while tracking |
| ts_en | input | 1 | Allow phase-step suppression on state changes |
| normal_o | output | 1 | Block is tracking the reference |
| holdover_o | output | 1 | Block is in automatic or forced holdover |
| fast_lock_o | output | 1 | Fast acquisition active toward the loop |
| ts_o | output | 1 | One-cycle phase-step suppression request |
| lock_o | output | 1 | Lock-time budget has elapsed in tracking |

## Verification
On every cycle the assertions check the following:
- The indicators are exclusive, and fast acquisition and the lock flag appear only in tracking.
- Nothing happens before a valid start code.
- Loss of the reference under select 00 leads to holdover one edge later.
- Forced holdover persists, and the reserved code freezes the state.
- The automatic return never raises suppression.

The bench scenarios show the exact three-edge select latency, the single-cycle width of the suppression pulse, the start gating after reset, and the precise edge on which the lock flag rises for each budget.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_NORM   = 2'd1,
    ST_AUTO   = 2'd2,
    ST_FORCED = 2'd3
  } clk_mode_e;

  localparam logic [1:0] SEL_NORM = 2'b00;
  localparam logic [1:0] SEL_HOLD = 2'b01;
  localparam logic [1:0] SEL_FREE = 2'b10;
  localparam logic [1:0] SEL_RSVD = 2'b11;

  // A select code that may start the block out of reset.
  function automatic logic is_start_code(logic [1:0] sel);
    return (sel == SEL_NORM) || (sel == SEL_FREE);
  endfunction

  // Next operating state from the current state, synchronized select,
  // reference status and start permission.
  function automatic clk_mode_e mode_next(clk_mode_e cur, logic [1:0] sel,
                                          logic ref_ok, logic started);
    clk_mode_e nxt;
    nxt = cur;
    unique case (sel)
      SEL_RSVD: nxt = cur;
      SEL_HOLD: nxt = started ? ST_FORCED : cur;
      SEL_FREE: nxt = ST_FREE;
      default: begin
        if (ref_ok) begin
          nxt = ST_NORM;
        end else begin
          unique case (cur)
            ST_FREE: nxt = ST_FREE;
            default: nxt = ST_AUTO;
          endcase
        end
      end
    endcase
    return nxt;
  endfunction

  // Return path that must not trigger phase-step suppression.
  function automatic logic is_auto_return(clk_mode_e cur, clk_mode_e nxt);
    return (cur == ST_AUTO) && (nxt == ST_NORM);
  endfunction

endpackage

// File: rtl/mode_sel_sync.sv
module mode_sel_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import sync_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_s,
  input  logic       ref_valid,
  input  logic       ts_en,
  output clk_mode_e  state,
  output logic       started,
  output logic       auto_ret,
  output logic       ts_o
);

  clk_mode_e state_q, state_d;
  logic      started_q, started_eff;
  logic      changed;

  assign started_eff = started_q | is_start_code(sel_s);
  assign state_d     = mode_next(state_q, sel_s, ref_valid, started_eff);
  assign changed     = (state_d != state_q);
  assign auto_ret    = is_auto_return(state_q, state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_FREE;
      started_q <= 1'b0;
      ts_o      <= 1'b0;
    end else begin
      state_q   <= state_d;
      started_q <= started_eff;
      ts_o      <= ts_en & changed & ~auto_ret;
    end
  end

  assign state   = state_q;
  assign started = started_q;

endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
  parameter int FAST_CNT = 8,
  parameter int SLOW_CNT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_normal,
  input  logic fast_req,
  output logic lock_o
);

  localparam int CW = $clog2(SLOW_CNT + 1);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_CNT);
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_CNT);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  function automatic logic [CW-1:0] budget(logic fast);
    return fast ? FAST_LIM : SLOW_LIM;
  endfunction

  assign limit = budget(fast_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!in_normal)       cnt <= '0;
    else if (cnt != SLOW_LIM)  cnt <= cnt + 1'b1;
  end

  assign lock_o = in_normal && (cnt >= limit);

endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
  import sync_mode_pkg::*;
#(
  parameter int FAST_CNT = 8,
  parameter int SLOW_CNT = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       ref_valid,
  input  logic       fast_req,
  input  logic       ts_en,
  output logic       normal_o,
  output logic       holdover_o,
  output logic       fast_lock_o,
  output logic       ts_o,
  output logic       lock_o
);

  logic [1:0] sel_s;
  clk_mode_e  state;
  logic       started;
  logic       auto_ret;
  logic       in_normal;

  mode_sel_sync #(
    .W(2), .STAGES(SYNC_STAGES), .RST_VAL(SEL_RSVD)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(mode_sel), .q(sel_s)
  );

  mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .ref_valid(ref_valid),
    .ts_en(ts_en), .state(state), .started(started),
    .auto_ret(auto_ret), .ts_o(ts_o)
  );

  assign in_normal = (state == ST_NORM);

  lock_timer #(
    .FAST_CNT(FAST_CNT), .SLOW_CNT(SLOW_CNT)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .in_normal(in_normal),
    .fast_req(fast_req), .lock_o(lock_o)
  );

  assign normal_o    = in_normal;
  assign holdover_o  = (state == ST_AUTO) || (state == ST_FORCED);
  assign fast_lock_o = in_normal & fast_req;

endmodule

// File: rtl/sync_mode_ctrl_chk.sv
module sync_mode_ctrl_chk
  import sync_mode_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ref_valid,
  input logic [1:0] sel_s,
  input logic [1:0] state,
  input logic       started,
  input logic       auto_ret,
  input logic       normal_o,
  input logic       holdover_o,
  input logic       fast_lock_o,
  input logic       ts_o,
  input logic       lock_o
);

  a_r2_idle_until_start: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (!normal_o && !holdover_o));

  a_r5_loss_to_holdover: assert property (@(posedge clk) disable iff (!rst_n)
    (normal_o && !ref_valid && sel_s == SEL_NORM) |=> holdover_o);

  a_r6_forced_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FORCED && sel_s == SEL_HOLD) |=> (state == ST_FORCED));

  a_r7_indicators_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(normal_o && holdover_o));

  a_r8_fast_only_tracking: assert property (@(posedge clk) disable iff (!rst_n)
    fast_lock_o |-> normal_o);

  a_r9_quiet_auto_return: assert property (@(posedge clk) disable iff (!rst_n)
    auto_ret |=> !ts_o);

  a_r10_lock_only_tracking: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> normal_o);

  a_r10_lock_low_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(normal_o) |-> !lock_o);

  a_r11_reserved_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s == SEL_RSVD) |=> $stable(state));

endmodule

bind sync_mode_ctrl sync_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .sel_s(sel_s),
  .state(state), .started(started), .auto_ret(auto_ret),
  .normal_o(normal_o), .holdover_o(holdover_o), .fast_lock_o(fast_lock_o),
  .ts_o(ts_o), .lock_o(lock_o)
);

// File: tb/sync_mode_ctrl_test.sv
module sync_mode_ctrl_test;

  localparam int CLK_P = 10;
  localparam int FAST_CNT = 8;
  localparam int SLOW_CNT = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b01;
  logic ref_valid = 1'b1;
  logic fast_req = 1'b0;
  logic ts_en = 1'b1;
  logic normal_o, holdover_o, fast_lock_o, ts_o, lock_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sync_mode_ctrl #(.FAST_CNT(FAST_CNT), .SLOW_CNT(SLOW_CNT)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_valid(ref_valid),
    .fast_req(fast_req), .ts_en(ts_en), .normal_o(normal_o),
    .holdover_o(holdover_o), .fast_lock_o(fast_lock_o), .ts_o(ts_o),
    .lock_o(lock_o)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic       rv;
    logic       fr;
    logic       te;
    logic [2:0] wt;
    logic [3:0] exp;   // {normal, holdover, fast_lock, ts}
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [0:NV-1] = '{
    '{2'b00, 1'b1, 1'b0, 1'b1, 3'd2, 4'b0000}, // 0  R3 not yet applied
    '{2'b00, 1'b1, 1'b0, 1'b1, 3'd1, 4'b1001}, // 1  R3 third edge, ts pulse
    '{2'b00, 1'b1, 1'b0, 1'b1, 3'd1, 4'b1000}, // 2  R9 pulse one cycle
    '{2'b00, 1'b1, 1'b1, 1'b1, 3'd1, 4'b1010}, // 3  R8 fast in tracking
    '{2'b00, 1'b0, 1'b1, 1'b1, 3'd1, 4'b0101}, // 4  R5 loss to auto holdover
    '{2'b00, 1'b1, 1'b1, 1'b1, 3'd1, 4'b1010}, // 5  R6 auto return, no ts
    '{2'b01, 1'b1, 1'b0, 1'b0, 3'd3, 4'b0100}, // 6  R4 forced holdover
    '{2'b01, 1'b0, 1'b0, 1'b0, 3'd1, 4'b0100}, // 7  R7 holdover indicator
    '{2'b01, 1'b1, 1'b0, 1'b0, 3'd2, 4'b0100}, // 8  R6 forced no return
    '{2'b11, 1'b1, 1'b0, 1'b1, 3'd3, 4'b0100}, // 9  R11 reserved holds
    '{2'b11, 1'b0, 1'b0, 1'b1, 3'd1, 4'b0100}, // 10 R11
    '{2'b10, 1'b0, 1'b0, 1'b1, 3'd3, 4'b0001}, // 11 R4 free-run
    '{2'b00, 1'b0, 1'b0, 1'b1, 3'd3, 4'b0000}, // 12 R4 free-run kept
    '{2'b00, 1'b1, 1'b0, 1'b1, 3'd1, 4'b1001}, // 13 R4 free-run to tracking
    '{2'b11, 1'b1, 1'b0, 1'b1, 3'd3, 4'b1000}, // 14 R11
    '{2'b11, 1'b0, 1'b0, 1'b1, 3'd1, 4'b1000}, // 15 R11 no auto holdover
    '{2'b01, 1'b0, 1'b0, 1'b1, 3'd3, 4'b0101}, // 16 R4 forced with ts
    '{2'b00, 1'b0, 1'b0, 1'b1, 3'd3, 4'b0101}, // 17 R4 forced to auto
    '{2'b00, 1'b1, 1'b0, 1'b1, 3'd1, 4'b1000}  // 18 R9 auto return quiet
  };

  function automatic string row_tag(int i);
    case (i)
      0, 1:                   return "R3";
      2, 18:                  return "R9";
      3:                      return "R8";
      4:                      return "R5";
      5, 8:                   return "R6";
      7:                      return "R7";
      9, 10, 14, 15:          return "R11";
      default:                return "R4";
    endcase
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {normal_o, holdover_o, fast_lock_o, ts_o, lock_o};
  endfunction

  initial begin
    // R1: reset state, during and right after reset
    tick(2);
    check("R1 in reset", outs(), 5'b00000);
    rst_n = 1'b1;
    tick(1);
    check("R1 after release", outs(), 5'b00000);

    // R2: hold and reserved codes before a start code are ignored
    tick(4);
    check("R2 hold ignored", outs(), 5'b00000);
    mode_sel = 2'b11;
    tick(5);
    check("R2 reserved ignored", outs(), 5'b00000);

    for (int i = 0; i < NV; i++) begin
      mode_sel  = TBL[i].sel;
      ref_valid = TBL[i].rv;
      fast_req  = TBL[i].fr;
      ts_en     = TBL[i].te;
      tick(int'(TBL[i].wt));
      checks++;
      if ({normal_o, holdover_o, fast_lock_o, ts_o} !== TBL[i].exp) begin
        errors++;
        $display("FAIL %s row %0d: got %b expected %b", row_tag(i), i,
                 {normal_o, holdover_o, fast_lock_o, ts_o}, TBL[i].exp);
      end
    end

    // R10: slow budget, counted from entry on the last row
    tick(SLOW_CNT - 1);
    check("R10 slow not yet", {normal_o, lock_o, 3'b000}, 5'b10000);
    tick(1);
    check("R10 slow reached", {normal_o, lock_o, 3'b000}, 5'b11000);
    fast_req = 1'b1;
    tick(1);
    check("R10 lock kept", {normal_o, lock_o, 3'b000}, 5'b11000);
    ref_valid = 1'b0;
    tick(1);
    check("R10 cleared off tracking", {normal_o, lock_o, 3'b000}, 5'b00000);
    ref_valid = 1'b1;
    tick(1);
    check("R10 restart on entry", {normal_o, lock_o, 3'b000}, 5'b10000);
    tick(FAST_CNT - 1);
    check("R10 fast not yet", {normal_o, lock_o, 3'b000}, 5'b10000);
    tick(1);
    check("R10 fast reached", {normal_o, lock_o, 3'b000}, 5'b11000);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule